// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block gives supervisor software a timer interrupt of its own. It holds a 64-bit compare value and raises the supervisor timer pending bit (STI) while that value is unsigned less than or equal to a free-running 64-bit machine time input. It also owns one enable bit in the machine environment-configuration word. That bit hands STI over to the hardware comparison and opens the compare register to supervisor code.

The block sits beside a CSR file and sees every CSR request. It answers only the few addresses it owns and leaves every other address alone. For each owned address it decides in the request cycle whether the access is allowed at the current privilege level. It returns read data or flags an illegal instruction. On a 32-bit datapath the 64-bit compare value is reached as two separate halves. On a 64-bit datapath it is reached as one word.

Top module: `stc_timer_unit`

## Requirements
- R1: After reset the compare value reads as all ones at every owned compare address, and both the enable bit and STI read as zero.
- R2: Address 0x14D holds the low XLEN bits of the compare value, and with XLEN=32 address 0x15D holds bits 63:32. A write changes only the addressed half, and during the write the read data equals the value written.
- R3: While the enable bit is set and the feature is built in, STI equals (compare <= machine time, unsigned). It is registered, so it reflects operand values one clock later.
- R4: Machine privilege (2'b11) may always access the compare addresses. Supervisor privilege (2'b01) may access them only when the TM input and the enable bit are both 1. User (2'b00) and the reserved level (2'b10) are always refused.
- R5: The illegal flag is asserted combinationally only while a request to an owned address is refused, and a refused access changes no state. An address the block does not own gives no flag and zero read data.
- R6: The enable bit is bit XLEN-1 of address 0x31A when XLEN=32, and of address 0x30A when XLEN=64. It is accessible only at machine privilege. It can be written only when the feature is built in, and otherwise it reads as zero.
- R7: At address 0x344 machine software reads STI at bit 5. A write to bit 5 sets STI unless the feature is built in and the enable bit is set, in which case STI keeps its value and the write returns the kept value.
- R8: When the feature or supervisor mode is not built in, both compare addresses are illegal at every privilege.
- R9: With XLEN=64, address 0x15D is illegal at every privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CSR request present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Request is a write |
| csr_wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| tm_en | input | 1 | Timer bit of the machine counter-enable register |
| mtime | input | 64 | Machine time |
| csr_rdata | output | XLEN | Read data, or new contents on a write |
| illegal | output | 1 | Access refused or undefined |
| sti | output | 1 | Supervisor timer pending bit |

## Verification
The bench builds three instances. The first uses XLEN=32 with the feature built in, which reaches the split halves, the supervisor gating and the hardware-driven STI. The second uses XLEN=64 with the feature built in, which reaches the single-word compare write, the enable bit at position 63 and the refusal of the high-half address. The third uses XLEN=32 with the feature absent, which shows the compare addresses as undefined, the enable bit stuck at zero and STI left under software control. Compare values are chosen so that the equal case and a case where a signed compare would give the opposite answer are both exercised.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam logic [11:0] ADDR_CMP_LO = 12'h14D;
    localparam logic [11:0] ADDR_CMP_HI = 12'h15D;
    localparam logic [11:0] ADDR_ENV_LO = 12'h30A;
    localparam logic [11:0] ADDR_ENV_HI = 12'h31A;
    localparam logic [11:0] ADDR_PEND   = 12'h344;

    localparam int STI_BIT = 5;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CMP_LO,
        TGT_CMP_HI,
        TGT_ENV,
        TGT_PEND
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic legal;
        logic illegal;
    } dec_t;

    function automatic logic stc_priv_ok(logic [1:0] lvl, logic tm, logic stce);
        return (lvl == PRIV_M) || ((lvl == PRIV_S) && tm && stce);
    endfunction

endpackage

// File: rtl/stc_decode.sv
module stc_decode
    import stc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_STC   = 1'b1
) (
    input  logic        req_valid,
    input  logic [11:0] csr_addr,
    input  logic [1:0]  priv,
    input  logic        tm_en,
    input  logic        stce,
    output dec_t        dec
);
    localparam logic [11:0] ENV_ADDR    = (XLEN == 32) ? ADDR_ENV_HI : ADDR_ENV_LO;
    localparam bit          CMP_PRESENT = HAS_SMODE && HAS_STC;
    localparam bit          HI_PRESENT  = CMP_PRESENT && (XLEN == 32);

    tgt_e tgt;
    logic ok;

    always_comb begin
        tgt = TGT_NONE;
        ok  = 1'b0;
        if (csr_addr == ADDR_CMP_LO) begin
            tgt = TGT_CMP_LO;
            ok  = CMP_PRESENT && stc_priv_ok(priv, tm_en, stce);
        end else if (csr_addr == ADDR_CMP_HI) begin
            tgt = TGT_CMP_HI;
            ok  = HI_PRESENT && stc_priv_ok(priv, tm_en, stce);
        end else if (csr_addr == ENV_ADDR) begin
            tgt = TGT_ENV;
            ok  = (priv == PRIV_M);
        end else if (csr_addr == ADDR_PEND) begin
            tgt = TGT_PEND;
            ok  = (priv == PRIV_M);
        end
    end

    always_comb begin
        dec.tgt     = req_valid ? tgt : TGT_NONE;
        dec.legal   = req_valid && (tgt != TGT_NONE) && ok;
        dec.illegal = req_valid && (tgt != TGT_NONE) && !ok;
    end

endmodule

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wdata,
    output logic [63:0]     cmp_q
);
    localparam int HALF = 32;

    generate
        if (XLEN == 64) begin : g_full
            logic unused_wr_hi;
            assign unused_wr_hi = wr_hi;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cmp_q <= '1;
                end else if (wr_lo) begin
                    cmp_q <= wdata;
                end
            end
        end else begin : g_split
            always_ff @(posedge clk) begin
                if (rst) begin
                    cmp_q <= '1;
                end else begin
                    if (wr_lo) cmp_q[HALF-1:0]  <= wdata[HALF-1:0];
                    if (wr_hi) cmp_q[63:HALF]   <= wdata[HALF-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/stc_pend.sv
module stc_pend #(
    parameter bit HAS_STC = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        env_wr,
    input  logic        stce_wbit,
    input  logic        pend_wr,
    input  logic        sti_wbit,
    input  logic [63:0] cmp_q,
    input  logic [63:0] mtime,
    output logic        stce_q,
    output logic        hw_mode,
    output logic        sti_q
);
    assign hw_mode = HAS_STC && stce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stce_q <= 1'b0;
        end else if (env_wr) begin
            stce_q <= HAS_STC && stce_wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sti_q <= 1'b0;
        end else if (hw_mode) begin
            sti_q <= (cmp_q <= mtime);
        end else if (pend_wr) begin
            sti_q <= sti_wbit;
        end
    end

endmodule

// File: rtl/stc_timer_unit.sv
module stc_timer_unit
    import stc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_STC   = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [11:0]     csr_addr,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [1:0]      priv,
    input  logic            tm_en,
    input  logic [63:0]     mtime,
    output logic [XLEN-1:0] csr_rdata,
    output logic            illegal,
    output logic            sti
);
    localparam int STCE_BIT = XLEN - 1;

    dec_t        dec;
    logic [63:0] cmp_q;
    logic        stce_q;
    logic        hw_mode;
    logic        wr;

    stc_decode #(
        .XLEN     (XLEN),
        .HAS_SMODE(HAS_SMODE),
        .HAS_STC  (HAS_STC)
    ) u_dec (
        .req_valid(req_valid),
        .csr_addr (csr_addr),
        .priv     (priv),
        .tm_en    (tm_en),
        .stce     (stce_q),
        .dec      (dec)
    );

    assign wr = dec.legal && csr_we;

    stc_cmp_reg #(
        .XLEN(XLEN)
    ) u_cmp (
        .clk  (clk),
        .rst  (rst),
        .wr_lo(wr && (dec.tgt == TGT_CMP_LO)),
        .wr_hi(wr && (dec.tgt == TGT_CMP_HI)),
        .wdata(csr_wdata),
        .cmp_q(cmp_q)
    );

    stc_pend #(
        .HAS_STC(HAS_STC)
    ) u_pend (
        .clk      (clk),
        .rst      (rst),
        .env_wr   (wr && (dec.tgt == TGT_ENV)),
        .stce_wbit(csr_wdata[STCE_BIT]),
        .pend_wr  (wr && (dec.tgt == TGT_PEND)),
        .sti_wbit (csr_wdata[STI_BIT]),
        .cmp_q    (cmp_q),
        .mtime    (mtime),
        .stce_q   (stce_q),
        .hw_mode  (hw_mode),
        .sti_q    (sti)
    );

    always_comb begin
        csr_rdata = '0;
        if (dec.legal) begin
            case (dec.tgt)
                TGT_CMP_LO: csr_rdata = csr_we ? csr_wdata : cmp_q[XLEN-1:0];
                TGT_CMP_HI: csr_rdata = csr_we ? csr_wdata : cmp_q[63 -: XLEN];
                TGT_ENV:    csr_rdata[STCE_BIT] = csr_we ? (HAS_STC && csr_wdata[STCE_BIT]) : stce_q;
                TGT_PEND:   csr_rdata[STI_BIT]  = (csr_we && !hw_mode) ? csr_wdata[STI_BIT] : sti;
                default:    csr_rdata = '0;
            endcase
        end
    end

    assign illegal = dec.illegal;

endmodule

// File: rtl/stc_checker.sv
module stc_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [11:0] csr_addr,
    input logic [1:0]  priv,
    input logic        tm_en,
    input logic [63:0] mtime,
    input logic        illegal,
    input logic        sti,
    input logic [63:0] cmp_q,
    input logic        stce_q,
    input logic        hw_mode
);
    logic cmp_addr;
    assign cmp_addr = (csr_addr == 12'h14D) || (csr_addr == 12'h15D);

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!sti && !stce_q && (cmp_q == 64'hFFFF_FFFF_FFFF_FFFF)));

    p_sti_follows_cmp_r3: assert property (@(posedge clk) disable iff (rst)
        hw_mode |=> (sti == ($past(cmp_q) <= $past(mtime))));

    p_user_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmp_addr && (priv == 2'b00 || priv == 2'b10)) |-> illegal);

    p_sup_gated_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cmp_addr && priv == 2'b01 && !(tm_en && stce_q)) |-> illegal);

    p_illegal_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !illegal);

    p_refused_no_update_r5: assert property (@(posedge clk) disable iff (rst)
        illegal |=> ($stable(cmp_q) && $stable(stce_q)));

endmodule

bind stc_timer_unit stc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .csr_addr (csr_addr),
    .priv     (priv),
    .tm_en    (tm_en),
    .mtime    (mtime),
    .illegal  (illegal),
    .sti      (sti),
    .cmp_q    (cmp_q),
    .stce_q   (stce_q),
    .hw_mode  (hw_mode)
);

// File: tb/tb_stc_timer_unit.sv
`timescale 1ns/1ps
module tb_stc_timer_unit;

    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PR = 2'b10, PM = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  req_v = 3'b000;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [63:0] wd = '0;
    logic [1:0]  priv = PM;
    logic        tm = 1'b0;
    logic [63:0] mtime = '0;
    logic [31:0] rd0, rd2;
    logic [63:0] rd1;
    logic [2:0]  ill, sti;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    stc_timer_unit #(.XLEN(32), .HAS_SMODE(1'b1), .HAS_STC(1'b1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_v[0]), .csr_addr(addr), .csr_we(we),
        .csr_wdata(wd[31:0]), .priv(priv), .tm_en(tm), .mtime(mtime),
        .csr_rdata(rd0), .illegal(ill[0]), .sti(sti[0]));

    stc_timer_unit #(.XLEN(64), .HAS_SMODE(1'b1), .HAS_STC(1'b1)) dut64 (
        .clk(clk), .rst(rst), .req_valid(req_v[1]), .csr_addr(addr), .csr_we(we),
        .csr_wdata(wd), .priv(priv), .tm_en(tm), .mtime(mtime),
        .csr_rdata(rd1), .illegal(ill[1]), .sti(sti[1]));

    stc_timer_unit #(.XLEN(32), .HAS_SMODE(1'b1), .HAS_STC(1'b0)) dut_off (
        .clk(clk), .rst(rst), .req_valid(req_v[2]), .csr_addr(addr), .csr_we(we),
        .csr_wdata(wd[31:0]), .priv(priv), .tm_en(tm), .mtime(mtime),
        .csr_rdata(rd2), .illegal(ill[2]), .sti(sti[2]));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input int u, input logic [11:0] a, input bit w, input logic [63:0] d,
                       input logic [1:0] p, output logic [63:0] rd, output logic il);
        @(negedge clk);
        req_v = 3'(1 << u);
        addr  = a;
        we    = w;
        wd    = d;
        priv  = p;
        #1;
        case (u)
            0:       rd = {32'h0, rd0};
            1:       rd = rd1;
            default: rd = {32'h0, rd2};
        endcase
        il = ill[u];
        @(posedge clk);
        #1;
        req_v = 3'b000;
        we    = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_time(input logic [63:0] t);
        @(negedge clk);
        mtime = t;
        tick();
    endtask

    task automatic t_reset();
        logic [63:0] r; logic il;
        chk("R1 sti after reset", {63'h0, sti[0]}, 64'h0);
        acc(0, 12'h14D, 0, 0, PM, r, il);
        chk("R1 low half reset", r, 64'hFFFF_FFFF);
        acc(0, 12'h15D, 0, 0, PM, r, il);
        chk("R1 high half reset", r, 64'hFFFF_FFFF);
        acc(0, 12'h31A, 0, 0, PM, r, il);
        chk("R1 enable reset", r, 64'h0);
        acc(1, 12'h14D, 0, 0, PM, r, il);
        chk("R1 64-bit compare reset", r, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_halves();
        logic [63:0] r; logic il;
        acc(0, 12'h14D, 1, 64'h1234_5678, PM, r, il);
        chk("R2 write low returns new", r, 64'h1234_5678);
        acc(0, 12'h15D, 0, 0, PM, r, il);
        chk("R2 high untouched", r, 64'hFFFF_FFFF);
        acc(0, 12'h15D, 1, 64'h0, PM, r, il);
        chk("R2 write high returns new", r, 64'h0);
        acc(0, 12'h14D, 0, 0, PM, r, il);
        chk("R2 low untouched by high write", r, 64'h1234_5678);
    endtask

    task automatic t_sw_sti();
        logic [63:0] r; logic il;
        acc(0, 12'h344, 1, 64'h20, PM, r, il);
        chk("R7 software sets sti", {63'h0, sti[0]}, 64'h1);
        acc(0, 12'h344, 0, 0, PM, r, il);
        chk("R7 pending read bit 5", r, 64'h20);
        acc(0, 12'h344, 1, 64'h0, PM, r, il);
        chk("R7 software clears sti", {63'h0, sti[0]}, 64'h0);
    endtask

    task automatic t_gating();
        logic [63:0] r; logic il;
        tm = 1'b1;
        acc(0, 12'h14D, 1, 64'hDEAD, PS, r, il);
        chk("R4 supervisor refused without enable", {63'h0, il}, 64'h1);
        acc(0, 12'h14D, 0, 0, PM, r, il);
        chk("R5 refused write left value", r, 64'h1234_5678);
        acc(0, 12'h31A, 1, 64'hFFFF_FFFF, PS, r, il);
        chk("R6 enable is machine-only", {63'h0, il}, 64'h1);
        acc(0, 12'h31A, 1, 64'hFFFF_FFFF, PM, r, il);
        chk("R6 enable write returns bit 31", r, 64'h8000_0000);
        acc(0, 12'h31A, 0, 0, PM, r, il);
        chk("R6 enable readback", r, 64'h8000_0000);
        tm = 1'b0;
        acc(0, 12'h14D, 0, 0, PS, r, il);
        chk("R4 supervisor refused without TM", {63'h0, il}, 64'h1);
        tm = 1'b1;
        acc(0, 12'h14D, 0, 0, PS, r, il);
        chk("R4 supervisor allowed", {il, r[62:0]}, 64'h1234_5678);
        acc(0, 12'h14D, 0, 0, PU, r, il);
        chk("R4 user refused", {63'h0, il}, 64'h1);
        acc(0, 12'h15D, 0, 0, PR, r, il);
        chk("R4 reserved level refused", {63'h0, il}, 64'h1);
    endtask

    task automatic t_compare();
        logic [63:0] r; logic il;
        acc(0, 12'h14D, 1, 64'd100, PM, r, il);
        tick();
        chk("R3 below compare", {63'h0, sti[0]}, 64'h0);
        set_time(64'd99);
        chk("R3 time one less", {63'h0, sti[0]}, 64'h0);
        @(negedge clk);
        mtime = 64'd100;
        #1;
        chk("R3 not before the edge", {63'h0, sti[0]}, 64'h0);
        tick();
        chk("R3 equal sets sti", {63'h0, sti[0]}, 64'h1);
        set_time(64'd101);
        chk("R3 above sets sti", {63'h0, sti[0]}, 64'h1);
        acc(0, 12'h15D, 1, 64'h8000_0000, PM, r, il);
        tick();
        chk("R3 high half raised clears", {63'h0, sti[0]}, 64'h0);
        set_time(64'h7FFF_FFFF_FFFF_FFFF);
        chk("R3 unsigned compare", {63'h0, sti[0]}, 64'h0);
        set_time(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R3 max time sets", {63'h0, sti[0]}, 64'h1);
    endtask

    task automatic t_masked();
        logic [63:0] r; logic il;
        acc(0, 12'h344, 1, 64'h0, PM, r, il);
        chk("R7 masked write returns kept", r, 64'h20);
        tick();
        chk("R7 masked clear ignored", {63'h0, sti[0]}, 64'h1);
        set_time(64'h0);
        acc(0, 12'h344, 1, 64'h20, PM, r, il);
        tick();
        chk("R7 masked set ignored", {63'h0, sti[0]}, 64'h0);
    endtask

    task automatic t_foreign();
        logic [63:0] r; logic il;
        acc(0, 12'h300, 1, 64'hFFFF_FFFF, PM, r, il);
        chk("R5 foreign address no flag", {il, r[62:0]}, 64'h0);
        acc(0, 12'h14D, 0, 0, PU, r, il);
        chk("R5 refused read data zero", r, 64'h0);
    endtask

    task automatic t_absent();
        logic [63:0] r; logic il;
        acc(2, 12'h14D, 0, 0, PM, r, il);
        chk("R8 low undefined", {63'h0, il}, 64'h1);
        acc(2, 12'h15D, 1, 64'h5, PM, r, il);
        chk("R8 high undefined", {63'h0, il}, 64'h1);
        acc(2, 12'h31A, 1, 64'hFFFF_FFFF, PM, r, il);
        chk("R6 enable stuck zero on write", r, 64'h0);
        acc(2, 12'h31A, 0, 0, PM, r, il);
        chk("R6 enable reads zero", r, 64'h0);
        acc(2, 12'h344, 1, 64'h20, PM, r, il);
        chk("R7 software owns sti when absent", {63'h0, sti[2]}, 64'h1);
    endtask

    task automatic t_wide();
        logic [63:0] r; logic il;
        acc(1, 12'h15D, 0, 0, PM, r, il);
        chk("R9 high address illegal at 64", {63'h0, il}, 64'h1);
        acc(1, 12'h14D, 1, 64'h0123_4567_89AB_CDEF, PM, r, il);
        chk("R2 full write returns new", r, 64'h0123_4567_89AB_CDEF);
        acc(1, 12'h14D, 0, 0, PM, r, il);
        chk("R2 full readback", r, 64'h0123_4567_89AB_CDEF);
        acc(1, 12'h30A, 1, 64'h8000_0000_0000_0000, PM, r, il);
        chk("R6 enable at bit 63", r, 64'h8000_0000_0000_0000);
        tick();
        chk("R3 64-bit below", {63'h0, sti[1]}, 64'h0);
        set_time(64'h0123_4567_89AB_CDEF);
        chk("R3 64-bit equal", {63'h0, sti[1]}, 64'h1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_halves();
        t_sw_sti();
        t_gating();
        t_compare();
        t_masked();
        t_foreign();
        t_absent();
        t_wide();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule